// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block sits in front of a page lookup unit and decides, for every 32-bit virtual address it accepts, how that address becomes a physical one. There are three routes. When translation is switched off, the address comes back unchanged with read, write and execute all granted. When translation is on and a privileged access falls into one of the sixteen top-level segments that is marked as directly mapped, the top nibble is replaced by a 4-bit physical base for that segment. Every other access goes to the page lookup unit over a valid/ready request, and that unit's answer is returned.

An access is offered with `acc_valid` and taken when `acc_ready` is high at a rising edge. A bypass result (disabled or directly mapped) appears on the result outputs with `res_valid` high in the cycle after acceptance. A paged access raises `pl_req_valid` in the cycle after acceptance. It holds that request until `pl_req_ready` is seen, then waits for `pl_rsp_valid`. The response is registered and shows on the result outputs one cycle later. Only one paged access is in flight at a time.

Top module: `seg_xlate_front`

## Requirements
- R1: Translation is on only when bit 3 or bit 2 of `cfg_global` is set; all other bits are ignored. With translation off, the result one cycle after acceptance has `res_paddr` equal to the virtual address, `res_perm` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute), `res_miss` = 0, and no lookup request is made.
- R2: The segment number is virtual address bits 31:28. The segment is directly mapped when translation is on, `acc_user` is 0 and bit `seg` of `cfg_seg` is 1.
- R3: The base nibble of segment `s` is bits 4*(s mod 8)+3 : 4*(s mod 8) of `base_lo` for s < 8, and the same nibble position of `base_hi` for s >= 8.
- R4: A directly mapped access yields, one cycle after acceptance, `res_paddr` = {base nibble, vaddr[27:0]}, `res_perm` = 3'b111 and `res_miss` = 0, with no lookup request.
- R5: Any access with translation on that is not directly mapped, including every user access whatever `cfg_seg` says, raises `pl_req_valid` in the cycle after acceptance and carries the virtual address and user flag.
- R6: While `pl_req_valid` is high and `pl_req_ready` is low, the request and its whole payload stay unchanged. `pl_req_valid` drops after the edge where `pl_req_ready` is seen.
- R7: Access type encoding on `acc_kind` is 0 read, 1 write, 2 execute, 3 read. `pl_req_instr` is 1 only for execute. `pl_req_kind` carries the type with 3 mapped to 0.
- R8: When `pl_rsp_valid` is seen after the request handshake, the next cycle has `res_valid` = 1 with `res_paddr`, `res_perm` and `res_miss` equal to the response's values. `res_valid` is a single-cycle pulse.
- R9: From acceptance of a paged access until its response is taken, `acc_ready` is 0, and an access offered meanwhile is neither taken nor produces a result.
- R10: During reset `acc_ready` = 1, `res_valid` = 0 and `pl_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Front end can take an access |
| acc_vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| acc_user | input | 1 | Access is from user mode |
| cfg_global | input | 32 | Global config; bits 3:2 enable translation |
| cfg_seg | input | 16 | One direct-map bit per segment |
| base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| pl_req_valid | output | 1 | Request to the page lookup unit |
| pl_req_ready | input | 1 | Lookup unit takes the request |
| pl_req_vaddr | output | 32 | Requested virtual address |
| pl_req_kind | output | 2 | Normalised access type |
| pl_req_instr | output | 1 | 1 selects the instruction lookup, 0 the data lookup |
| pl_req_user | output | 1 | User flag of the request |
| pl_rsp_valid | input | 1 | Lookup response present |
| pl_rsp_paddr | input | 32 | Lookup physical address |
| pl_rsp_perm | input | 3 | Lookup permissions |
| pl_rsp_miss | input | 1 | Lookup missed |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Physical address |
| res_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| res_miss | output | 1 | Translation missed |

## Verification
The assertions watch on every cycle that a disabled or directly mapped access returns full permissions and no miss on the following cycle, that a user access with translation on always becomes a request, that a stalled request keeps its payload, that the request type is never the reserved code, that acceptance is blocked while a request is outstanding, and that a taken response is copied to the result. Which nibble of which base register lands in the top address bits, and that config bits other than 3:2 have no effect, only show in the bench's sweep over every segment, user flag, access type and enable pattern, where the expected address is computed arithmetically.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int VA_W        = 32;
  localparam int SEG_W       = 4;
  localparam int SEG_N       = 1 << SEG_W;
  localparam int NIB_W       = 4;
  localparam int BASE_W      = 32;
  localparam int NIB_PER_REG = BASE_W / NIB_W;
  localparam int OFS_W       = VA_W - SEG_W;
  localparam int PERM_W      = 3;
  localparam int EN_LSB      = 2;
  localparam int EN_MSB      = 3;

  localparam logic [PERM_W-1:0] PERM_ALL = '1;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // Translation is on when any enable bit in the global config is set.
  function automatic logic xlate_enabled(input logic [31:0] g);
    return |g[EN_MSB:EN_LSB];
  endfunction

  function automatic logic [SEG_W-1:0] seg_of(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: SEG_W];
  endfunction

  // Reserved type code behaves as a read.
  function automatic acc_kind_e norm_kind(input logic [1:0] k);
    acc_kind_e r;
    case (k)
      2'd1:    r = ACC_WRITE;
      2'd2:    r = ACC_EXEC;
      default: r = ACC_READ;
    endcase
    return r;
  endfunction

  // Replace the segment nibble of the address by the physical base.
  function automatic logic [VA_W-1:0] splice_base(input logic [NIB_W-1:0] nib,
                                                  input logic [VA_W-1:0] va);
    return {nib, va[OFS_W-1:0]};
  endfunction

endpackage

// File: rtl/xlate_route.sv
module xlate_route
  import xlate_pkg::*;
(
  input  logic [VA_W-1:0]   vaddr,
  input  logic [1:0]        kind,
  input  logic              user,
  input  logic [31:0]       cfg_global,
  input  logic [SEG_N-1:0]  cfg_seg,
  input  logic [BASE_W-1:0] base_lo,
  input  logic [BASE_W-1:0] base_hi,
  output logic              xlate_on,
  output logic              direct_hit,
  output logic              bypass,
  output logic [VA_W-1:0]   bypass_paddr,
  output acc_kind_e         kind_norm,
  output logic              use_instr
);

  logic [SEG_W-1:0] seg;
  logic [NIB_W-1:0] seg_nib [SEG_N];
  logic [NIB_W-1:0] nib_sel;

  // One base nibble per segment, low register for the lower half.
  for (genvar g = 0; g < SEG_N; g++) begin : g_nib
    if (g < NIB_PER_REG) begin : g_lo
      assign seg_nib[g] = base_lo[(g % NIB_PER_REG)*NIB_W +: NIB_W];
    end else begin : g_hi
      assign seg_nib[g] = base_hi[(g % NIB_PER_REG)*NIB_W +: NIB_W];
    end
  end

  always_comb begin
    seg        = seg_of(vaddr);
    nib_sel    = seg_nib[seg];
    xlate_on   = xlate_enabled(cfg_global);
    direct_hit = xlate_on && !user && cfg_seg[seg];
    bypass     = !xlate_on || direct_hit;
    if (!xlate_on) bypass_paddr = vaddr;
    else           bypass_paddr = splice_base(nib_sel, vaddr);
    kind_norm  = norm_kind(kind);
    use_instr  = (kind_norm == ACC_EXEC);
  end

endmodule

// File: rtl/xlate_lookup_port.sv
module xlate_lookup_port
  import xlate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VA_W-1:0] start_vaddr,
  input  acc_kind_e       start_kind,
  input  logic            start_instr,
  input  logic            start_user,
  output logic            busy,
  output logic            pl_req_valid,
  input  logic            pl_req_ready,
  output logic [VA_W-1:0] pl_req_vaddr,
  output logic [1:0]      pl_req_kind,
  output logic            pl_req_instr,
  output logic            pl_req_user,
  input  logic            pl_rsp_valid,
  output logic            rsp_take
);

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} pstate_e;
  pstate_e st;

  logic [VA_W-1:0] va_q;
  acc_kind_e       kind_q;
  logic            instr_q, user_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      va_q    <= '0;
      kind_q  <= ACC_READ;
      instr_q <= 1'b0;
      user_q  <= 1'b0;
    end else begin
      case (st)
        P_IDLE: if (start) begin
          st      <= P_REQ;
          va_q    <= start_vaddr;
          kind_q  <= start_kind;
          instr_q <= start_instr;
          user_q  <= start_user;
        end
        P_REQ:  if (pl_req_ready) st <= P_WAIT;
        P_WAIT: if (pl_rsp_valid) st <= P_IDLE;
        default: st <= P_IDLE;
      endcase
    end
  end

  assign busy         = (st != P_IDLE);
  assign pl_req_valid = (st == P_REQ);
  assign pl_req_vaddr = va_q;
  assign pl_req_kind  = kind_q;
  assign pl_req_instr = instr_q;
  assign pl_req_user  = user_q;
  assign rsp_take     = (st == P_WAIT) && pl_rsp_valid;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req_valid && !pl_req_ready |=> pl_req_valid && $stable(pl_req_vaddr)
      && $stable(pl_req_kind) && $stable(pl_req_instr) && $stable(pl_req_user));

  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req_valid && pl_req_ready |=> !pl_req_valid);

  p_kind_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req_valid |-> (pl_req_kind != 2'd3) && (pl_req_instr == (pl_req_kind == 2'd2)));

endmodule

// File: rtl/xlate_result_reg.sv
module xlate_result_reg
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_bypass,
  input  logic [VA_W-1:0]   bypass_paddr,
  input  logic              load_rsp,
  input  logic [VA_W-1:0]   rsp_paddr,
  input  logic [PERM_W-1:0] rsp_perm,
  input  logic              rsp_miss,
  output logic              res_valid,
  output logic [VA_W-1:0]   res_paddr,
  output logic [PERM_W-1:0] res_perm,
  output logic              res_miss
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_paddr <= '0;
      res_perm  <= '0;
      res_miss  <= 1'b0;
    end else if (load_bypass) begin
      res_valid <= 1'b1;
      res_paddr <= bypass_paddr;
      res_perm  <= PERM_ALL;
      res_miss  <= 1'b0;
    end else if (load_rsp) begin
      res_valid <= 1'b1;
      res_paddr <= rsp_paddr;
      res_perm  <= rsp_perm;
      res_miss  <= rsp_miss;
    end else begin
      res_valid <= 1'b0;
    end
  end

  p_rsp_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_rsp |=> res_valid && res_paddr == $past(rsp_paddr)
      && res_perm == $past(rsp_perm) && res_miss == $past(rsp_miss));

endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
  import xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic [31:0]        acc_vaddr,
  input  logic [1:0]         acc_kind,
  input  logic               acc_user,
  input  logic [31:0]        cfg_global,
  input  logic [15:0]        cfg_seg,
  input  logic [31:0]        base_lo,
  input  logic [31:0]        base_hi,
  output logic               pl_req_valid,
  input  logic               pl_req_ready,
  output logic [31:0]        pl_req_vaddr,
  output logic [1:0]         pl_req_kind,
  output logic               pl_req_instr,
  output logic               pl_req_user,
  input  logic               pl_rsp_valid,
  input  logic [31:0]        pl_rsp_paddr,
  input  logic [2:0]         pl_rsp_perm,
  input  logic               pl_rsp_miss,
  output logic               res_valid,
  output logic [31:0]        res_paddr,
  output logic [2:0]         res_perm,
  output logic               res_miss
);

  logic            xlate_on, route_direct, route_bypass, use_instr;
  logic [VA_W-1:0] bypass_paddr;
  acc_kind_e       kind_norm;
  logic            busy, acc_fire, start_paged, load_bypass, rsp_take;

  assign acc_ready   = !busy;
  assign acc_fire    = acc_valid && acc_ready;
  assign start_paged = acc_fire && !route_bypass;
  assign load_bypass = acc_fire && route_bypass;

  xlate_route u_route (
    .vaddr(acc_vaddr), .kind(acc_kind), .user(acc_user),
    .cfg_global(cfg_global), .cfg_seg(cfg_seg),
    .base_lo(base_lo), .base_hi(base_hi),
    .xlate_on(xlate_on), .direct_hit(route_direct), .bypass(route_bypass),
    .bypass_paddr(bypass_paddr), .kind_norm(kind_norm), .use_instr(use_instr)
  );

  xlate_lookup_port u_port (
    .clk(clk), .rst_n(rst_n),
    .start(start_paged), .start_vaddr(acc_vaddr), .start_kind(kind_norm),
    .start_instr(use_instr), .start_user(acc_user),
    .busy(busy),
    .pl_req_valid(pl_req_valid), .pl_req_ready(pl_req_ready),
    .pl_req_vaddr(pl_req_vaddr), .pl_req_kind(pl_req_kind),
    .pl_req_instr(pl_req_instr), .pl_req_user(pl_req_user),
    .pl_rsp_valid(pl_rsp_valid), .rsp_take(rsp_take)
  );

  xlate_result_reg u_res (
    .clk(clk), .rst_n(rst_n),
    .load_bypass(load_bypass), .bypass_paddr(bypass_paddr),
    .load_rsp(rsp_take), .rsp_paddr(pl_rsp_paddr),
    .rsp_perm(pl_rsp_perm), .rsp_miss(pl_rsp_miss),
    .res_valid(res_valid), .res_paddr(res_paddr),
    .res_perm(res_perm), .res_miss(res_miss)
  );

  p_disabled_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !xlate_on |=> res_valid && res_paddr == $past(acc_vaddr)
      && res_perm == 3'b111 && !res_miss && !pl_req_valid);

  p_direct_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && route_direct |=> res_valid && res_perm == 3'b111 && !res_miss
      && res_paddr[27:0] == $past(acc_vaddr[27:0]) && !pl_req_valid);

  p_user_paged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_user && xlate_on |=> pl_req_valid && !res_valid
      && pl_req_vaddr == $past(acc_vaddr));

  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req_valid |-> !acc_ready);

endmodule

// File: tb/sim_seg_xlate_front.sv
module sim_seg_xlate_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_ready;
  logic [31:0] acc_vaddr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_user = 1'b0;
  logic [31:0] cfg_global = '0, base_lo = '0, base_hi = '0;
  logic [15:0] cfg_seg = '0;
  logic        pl_req_valid, pl_req_ready = 1'b0;
  logic [31:0] pl_req_vaddr;
  logic [1:0]  pl_req_kind;
  logic        pl_req_instr, pl_req_user;
  logic        pl_rsp_valid = 1'b0;
  logic [31:0] pl_rsp_paddr = '0;
  logic [2:0]  pl_rsp_perm = '0;
  logic        pl_rsp_miss = 1'b0;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic [2:0]  res_perm;
  logic        res_miss;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  seg_xlate_front u0 (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nib(input logic [3:0] s, input logic [31:0] lo,
                                         input logic [31:0] hi);
    logic [31:0] src = s[3] ? hi : lo;
    return 4'((src >> (s[2:0] * 4)) & 32'hF);
  endfunction

  task automatic run_vec(input int i, input logic [3:0] s, input logic u,
                         input logic [1:0] k, input logic [1:0] m);
    logic [31:0] va, exp_pa, rpa;
    logic        on, dir;
    logic [2:0]  rperm;
    logic        rmiss;
    int          stall;
    va  = {s, 28'(i * 32'h0013_579B + 32'h0ABC_0123)};
    on  = (m != 2'd0);
    @(negedge clk);
    acc_vaddr  = va;
    acc_kind   = k;
    acc_user   = u;
    cfg_global = 32'hF0F0_F0F3 | (32'(m) << 2);
    cfg_seg    = i[0] ? 16'h3C5A : 16'hC3A5;
    base_lo    = 32'h1F2E_3D4C + 32'(i) * 32'h0101_0101;
    base_hi    = 32'hB7A6_9584 ^ (32'(i) * 32'h0110_0011);
    dir = on && !u && cfg_seg[s];
    exp_pa = !on ? va : {exp_nib(s, base_lo, base_hi), va[27:0]};
    chk(acc_ready, "R9 ready when idle", 32'(acc_ready), 1);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    if (!on || dir) begin
      chk(res_valid && res_paddr == exp_pa, dir ? "R3/R4 direct address" : "R1 passthrough",
          res_paddr, exp_pa);
      chk(res_perm == 3'b111 && !res_miss, dir ? "R4 perm" : "R1 perm",
          {28'd0, res_miss, res_perm}, 32'h7);
      chk(!pl_req_valid, "R2 no request on bypass", 32'(pl_req_valid), 0);
    end else begin
      chk(pl_req_valid && !res_valid, "R5 request raised", 32'(pl_req_valid), 1);
      chk(pl_req_vaddr == va && pl_req_user == u, "R5 payload", pl_req_vaddr, va);
      chk(pl_req_kind == ((k == 2'd3) ? 2'd0 : k), "R7 kind", 32'(pl_req_kind),
          32'((k == 2'd3) ? 2'd0 : k));
      chk(pl_req_instr == (k == 2'd2), "R7 instr select", 32'(pl_req_instr),
          32'(k == 2'd2));
      stall = i % 3;
      for (int c = 0; c < stall; c++) begin
        if (c == 0) begin
          acc_valid = 1'b1;
          acc_vaddr = ~va;
          cfg_global = 32'h0;
        end
        @(negedge clk);
        chk(!acc_ready && pl_req_valid && pl_req_vaddr == va, "R6/R9 stall hold",
            pl_req_vaddr, va);
        chk(!res_valid, "R9 no result while busy", 32'(res_valid), 0);
      end
      acc_valid = 1'b0;
      pl_req_ready = 1'b1;
      @(negedge clk);
      pl_req_ready = 1'b0;
      chk(!pl_req_valid && !acc_ready && !res_valid, "R6 request dropped",
          32'(pl_req_valid), 0);
      rpa   = ~va ^ 32'(i);
      rperm = {k == 2'd2, u, 1'b1};
      rmiss = va[13];
      pl_rsp_valid = 1'b1;
      pl_rsp_paddr = rpa;
      pl_rsp_perm  = rperm;
      pl_rsp_miss  = rmiss;
      @(negedge clk);
      pl_rsp_valid = 1'b0;
      chk(res_valid && res_paddr == rpa, "R8 response address", res_paddr, rpa);
      chk(res_perm == rperm && res_miss == rmiss, "R8 response perm/miss",
          {28'd0, res_miss, res_perm}, {28'd0, rmiss, rperm});
      chk(acc_ready, "R9 ready again", 32'(acc_ready), 1);
    end
    @(negedge clk);
    chk(!res_valid, "R8 single-cycle result", 32'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_ready && !res_valid && !pl_req_valid, "R10 reset state",
        {29'd0, acc_ready, res_valid, pl_req_valid}, 32'h4);
    rst_n = 1'b1;
    begin
      int i = 0;
      for (int s = 0; s < 16; s++)
        for (int u = 0; u < 2; u++)
          for (int k = 0; k < 4; k++)
            for (int m = 0; m < 4; m++) begin
              run_vec(i, 4'(s), 1'(u), 2'(k), 2'(m));
              i++;
            end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

endmodule